// File: doc/BRIEF.md
# Complementary Dead-Time Gate Sequencer

This block turns a single PWM command into two complementary switch-drive signals: a main power drive and an auxiliary drive. Each command edge turns one switch off at once. The opposite switch then turns on only after its own dead time, which is counted in clock cycles. A rising command edge releases the auxiliary switch and arms the turn-on dead time of the main switch. A falling edge releases the main switch and arms the turn-on dead time of the auxiliary switch.

Each dead-time timer has a zero-voltage-sense input. When that input is asserted during the wait, the wait ends early. An enable input puts the block to sleep: the main drive is held low and the auxiliary pin is released to high impedance. A mode input picks the auxiliary pin polarity. In inverted mode the pin is active-low, for a p-channel switch. In true-complementary mode the pin is active-high. The command and sense inputs are asynchronous and each passes through two synchronizing flops. The enable and mode inputs are synchronous to the clock.

Top module: `deadtime_seq`

## Requirements
- R1: Let E0 be the first clock edge that samples the command high after it was low. At edge E0+2 the auxiliary switch is off. At edge E0+2+T1 the main drive asserts, where T1 is the `dly_on` value.
- R2: Let F0 be the first clock edge that samples the command low after it was high. At edge F0+2 the main drive is low. At edge F0+2+T2 the auxiliary switch is on, where T2 is the `dly_off` value.
- R3: A delay value of 0 acts as 1 cycle. The delay input is sampled only at the edge that starts a wait, so changing it during a wait has no effect on that wait.
- R4: If a sense input is first sampled high at edge Z0 while its wait is running, the switch that timer controls turns on at edge Z0+2, or earlier if the count expires first. `zvs_main` ends the T1 wait and `zvs_aux` ends the T2 wait.
- R5: If the opposite command edge arrives while a wait is running, the pending turn-on is cancelled and that switch stays off.
- R6: When `enable` is sampled low, from the next edge on `main_drv` is 0 and `aux_oe` is 0 (the auxiliary pin is high impedance).
- R7: After reset or on leaving sleep, both switches are off and `aux_oe` is 1. Neither switch turns on until a new command edge is seen.
- R8: `aux_pin` equals the auxiliary on-state XOR the registered mode. When `aux_invert`=1 the pin is active-low and idles at 1. When `aux_invert`=0 the pin is active-high and idles at 0. A change of `aux_invert` forces both switches off, and the block then waits for the next command edge.
- R9: The main switch and the auxiliary switch are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 1 | Asynchronous PWM command |
| zvs_main | input | 1 | Asynchronous sense input that ends the main turn-on wait |
| zvs_aux | input | 1 | Asynchronous sense input that ends the auxiliary turn-on wait |
| enable | input | 1 | Low selects sleep |
| aux_invert | input | 1 | 1 selects an active-low auxiliary pin |
| dly_on | input | DLY_W | Main turn-on dead time, in cycles (T1) |
| dly_off | input | DLY_W | Auxiliary turn-on dead time, in cycles (T2) |
| main_drv | output | 1 | Main power switch drive, active high |
| aux_pin | output | 1 | Auxiliary switch drive level |
| aux_oe | output | 1 | Auxiliary pin output enable; 0 means high impedance |

## Verification
The bench measures the exact edge at which each switch turns on for several delay values, including a delay of zero. A design that counted one cycle too many or too few, or that let 0 wrap to the largest count, would assert at the wrong edge. Some command pulses are shorter than the dead time; a design without cancellation would fire the main drive after the command had already fallen. The bench also changes the delay value during a wait, wakes the block from sleep while the command is held high, and flips the polarity mode in the middle of a drive. A design that reloaded the delay mid-wait, that acted on a stale level after waking, or that left the auxiliary switch on across a polarity change would then fail the cycle-accurate comparison.

// File: rtl/dts_pkg.sv
// Shared types for the dead-time gate sequencer.
package dts_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_IDLE,
        ST_WAIT_MAIN,
        ST_MAIN_ON,
        ST_WAIT_AUX,
        ST_AUX_ON
    } seq_state_t;
endpackage

// File: rtl/dts_sync.sv
// Multi-bit flop-chain synchronizer.
// Assumes every bit is an independent level signal; no bus coherence is promised.
module dts_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-times the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dts_timer.sv
// Down-counting dead-time timer.
// A start pulse loads the delay (0 is treated as 1). The timer reports expiry
// when the count reaches zero. The delay input is looked at only on start.
module dts_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dly,
    output logic         expired
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    // Load on start, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (start)          cnt <= (dly == '0) ? '0 : dly - ONE;
        else if (cnt != '0)      cnt <= cnt - ONE;
    end

    assign expired = (cnt == '0);

    // R3: a delay of 0 or 1 expires on the first cycle of the wait
    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dly <= ONE) |=> expired);

    // R3: a running count is not disturbed by the delay input
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !expired) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/deadtime_seq.sv
// Complementary dead-time gate sequencer (top).
// Assumes: cmd, zvs_main and zvs_aux are asynchronous; enable and aux_invert
// are synchronous to clk. Outputs are registered from the next state, so
// they change only at clock edges and cannot glitch.
module deadtime_seq
    import dts_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd,
    input  logic             zvs_main,
    input  logic             zvs_aux,
    input  logic             enable,
    input  logic             aux_invert,
    input  logic [DLY_W-1:0] dly_on,
    input  logic [DLY_W-1:0] dly_off,
    output logic             main_drv,
    output logic             aux_pin,
    output logic             aux_oe
);
    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] raw_in;
    logic [N_ASYNC-1:0] syn_in;
    logic               cmd_s;
    logic               zm_s;
    logic               za_s;
    logic               cmd_prev;
    logic               rise_s;
    logic               fall_s;
    logic               mode_q;
    logic               mode_chg;
    logic               aux_on_q;
    logic               start_main;
    logic               start_aux;
    logic               exp_main;
    logic               exp_aux;
    seq_state_t         state;
    seq_state_t         nxt;

    assign raw_in = {zvs_aux, zvs_main, cmd};

    dts_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign cmd_s = syn_in[0];
    assign zm_s  = syn_in[1];
    assign za_s  = syn_in[2];

    // Remember the last synchronized command level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_prev <= 1'b0;
        else        cmd_prev <= cmd_s;
    end

    assign rise_s   = cmd_s & ~cmd_prev;
    assign fall_s   = ~cmd_s & cmd_prev;
    assign mode_chg = (aux_invert != mode_q);

    // Track the polarity mode; during reset it follows the input directly.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= aux_invert;
        else        mode_q <= aux_invert;
    end

    // Next-state logic: sleep first, then mode change, then edges and timers.
    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_SLEEP;
        end else if (mode_chg) begin
            nxt = ST_IDLE;
        end else begin
            case (state)
                ST_SLEEP:     nxt = ST_IDLE;
                ST_IDLE: begin
                    if (rise_s)      nxt = ST_WAIT_MAIN;
                    else if (fall_s) nxt = ST_WAIT_AUX;
                end
                ST_WAIT_MAIN: begin
                    if (fall_s)                nxt = ST_WAIT_AUX;
                    else if (exp_main || zm_s) nxt = ST_MAIN_ON;
                end
                ST_MAIN_ON: begin
                    if (fall_s) nxt = ST_WAIT_AUX;
                end
                ST_WAIT_AUX: begin
                    if (rise_s)               nxt = ST_WAIT_MAIN;
                    else if (exp_aux || za_s) nxt = ST_AUX_ON;
                end
                ST_AUX_ON: begin
                    if (rise_s) nxt = ST_WAIT_MAIN;
                end
                default:      nxt = ST_SLEEP;
            endcase
        end
    end

    assign start_main = (nxt == ST_WAIT_MAIN) && (state != ST_WAIT_MAIN);
    assign start_aux  = (nxt == ST_WAIT_AUX)  && (state != ST_WAIT_AUX);

    dts_timer #(.W(DLY_W)) u_t_main (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_main),
        .dly     (dly_on),
        .expired (exp_main)
    );

    dts_timer #(.W(DLY_W)) u_t_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_aux),
        .dly     (dly_off),
        .expired (exp_aux)
    );

    // State register and registered drive outputs decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            main_drv <= 1'b0;
            aux_on_q <= 1'b0;
            aux_oe   <= 1'b1;
            aux_pin  <= aux_invert;
        end else begin
            state    <= nxt;
            main_drv <= (nxt == ST_MAIN_ON);
            aux_on_q <= (nxt == ST_AUX_ON);
            aux_oe   <= (nxt != ST_SLEEP);
            aux_pin  <= (nxt == ST_AUX_ON) ^ aux_invert;
        end
    end

    // R9: while the main switch is on, the aux pin sits at its off level
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        main_drv |-> (aux_oe && (aux_pin == mode_q)));

    // R1: the main drive only rises after a dead-time wait
    p_main_after_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_drv) |-> ($past(state) == ST_WAIT_MAIN));

    // R1: a command rise releases the aux switch on the next edge
    p_rise_cut_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_s |=> (!aux_oe || (aux_pin == mode_q)));

    // R2: a command fall releases the main switch on the next edge
    p_fall_cut_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_s |=> !main_drv);

    // R6: sleep holds main low and floats the aux pin
    p_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!main_drv && !aux_oe));

    // R7: waking from sleep leaves both switches off and the pin driven
    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && enable) |=> (!main_drv && aux_oe && aux_pin == mode_q));

    // R8: a polarity change forces both switches off
    p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode_chg) |=> (!main_drv && aux_pin == mode_q));
endmodule

// File: tb/sim_deadtime_seq.sv
module sim_deadtime_seq;
    localparam int DLY_W = 8;
    localparam int M_SLEEP = 0, M_IDLE = 1, M_WM = 2, M_MON = 3, M_WA = 4, M_AON = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd = 1'b0, zvs_main = 1'b0, zvs_aux = 1'b0;
    logic enable = 1'b1, aux_invert = 1'b0;
    logic [DLY_W-1:0] dly_on = 8'd4, dly_off = 8'd4;
    logic main_drv, aux_pin, aux_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string tag = "";

    // reference model state
    int  m_st = M_IDLE;
    int  m_cnt = 0;
    bit  m_s1 = 0, m_s2 = 0, m_p = 0;
    bit  m_zm1 = 0, m_zm2 = 0, m_za1 = 0, m_za2 = 0;
    bit  m_mode = 0;

    always #2 clk = ~clk;

    deadtime_seq #(.DLY_W(DLY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .zvs_main(zvs_main), .zvs_aux(zvs_aux),
        .enable(enable), .aux_invert(aux_invert), .dly_on(dly_on), .dly_off(dly_off),
        .main_drv(main_drv), .aux_pin(aux_pin), .aux_oe(aux_oe)
    );

    function automatic int load_of(input logic [DLY_W-1:0] d);
        return (d == 0) ? 0 : int'(d) - 1;
    endfunction

    function automatic bit exp_main(input int st);
        return st == M_MON;
    endfunction

    function automatic bit exp_oe(input int st);
        return st != M_SLEEP;
    endfunction

    function automatic bit exp_pin(input int st, input bit mode);
        return (st == M_AON) ^ mode;
    endfunction

    function automatic string phase_req(input int st);
        case (st)
            M_SLEEP:     return "R6";
            M_IDLE:      return "R7";
            M_WM, M_MON: return "R1";
            default:     return "R2";
        endcase
    endfunction

    // Reference model of the requirements, advanced once per clock edge.
    always @(posedge clk) begin
        bit rise, fall;
        int nst;
        if (!rst_n) begin
            m_st = M_IDLE; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_p = 0;
            m_zm1 = 0; m_zm2 = 0; m_za1 = 0; m_za2 = 0; m_mode = aux_invert;
        end else begin
            rise = m_s2 && !m_p;
            fall = !m_s2 && m_p;
            nst = m_st;
            if (!enable) nst = M_SLEEP;
            else if (aux_invert != m_mode) nst = M_IDLE;
            else begin
                case (m_st)
                    M_SLEEP: nst = M_IDLE;
                    M_IDLE: begin
                        if (rise) begin nst = M_WM; m_cnt = load_of(dly_on); end
                        else if (fall) begin nst = M_WA; m_cnt = load_of(dly_off); end
                    end
                    M_WM: begin
                        if (fall) begin nst = M_WA; m_cnt = load_of(dly_off); end
                        else if (m_cnt == 0 || m_zm2) nst = M_MON;
                        else m_cnt--;
                    end
                    M_MON: if (fall) begin nst = M_WA; m_cnt = load_of(dly_off); end
                    M_WA: begin
                        if (rise) begin nst = M_WM; m_cnt = load_of(dly_on); end
                        else if (m_cnt == 0 || m_za2) nst = M_AON;
                        else m_cnt--;
                    end
                    default: if (rise) begin nst = M_WM; m_cnt = load_of(dly_on); end
                endcase
            end
            m_st = nst;
            m_p = m_s2; m_s2 = m_s1; m_s1 = cmd;
            m_zm2 = m_zm1; m_zm1 = zvs_main;
            m_za2 = m_za1; m_za1 = zvs_aux;
            m_mode = aux_invert;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        string rq;
        if (rst_n && !finished) begin
            rq = (tag != "") ? tag : phase_req(m_st);
            chk(main_drv == exp_main(m_st), {rq, " main_drv"}, main_drv, exp_main(m_st));
            chk(aux_oe == exp_oe(m_st), {rq, " aux_oe"}, aux_oe, exp_oe(m_st));
            chk(aux_pin == exp_pin(m_st, m_mode), {rq, " aux_pin"}, aux_pin, exp_pin(m_st, m_mode));
            // R9: never both switches on
            chk(!(main_drv && aux_oe && aux_pin != m_mode), "R9 overlap", main_drv, 0);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    // Counts negedges after a change until main_drv is high.
    task automatic cycles_to_main(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!main_drv && n < 400);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, hits;
        void'($urandom(32'h5eed_1234));
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk(main_drv == 0 && aux_oe == 1 && aux_pin == 0, "R7 reset", {main_drv, aux_oe, aux_pin}, 3'b010);
        #1;
        step(3);

        // R1: exact T1 timing
        tag = "R1"; dly_on = 8'd10; cmd = 1;
        cycles_to_main(n);
        chk(n == 13, "R1 turn-on latency", n, 13);
        step(5);

        // R2 then R3: zero delay acts as one
        tag = "R2"; dly_off = 8'd6; cmd = 0; step(20);
        tag = "R3"; dly_on = 8'd0; cmd = 1;
        cycles_to_main(n);
        chk(n == 4, "R3 zero delay", n, 4);
        cmd = 0; step(15);

        // R3: delay changed during a wait has no effect
        dly_on = 8'd20; cmd = 1; step(5); dly_on = 8'd2;
        n = 5;
        do begin @(negedge clk); n++; end while (!main_drv && n < 400);
        #1;
        chk(n == 23, "R3 mid-wait change", n, 23);
        cmd = 0; step(15);

        // R4: sense input ends the wait
        tag = "R4"; dly_on = 8'd200; cmd = 1; step(8); zvs_main = 1;
        cycles_to_main(n);
        chk(n == 3, "R4 early release", n, 3);
        zvs_main = 0; cmd = 0; step(3); zvs_aux = 1; dly_off = 8'd200; step(4);
        chk(aux_pin == 1, "R4 aux early release", aux_pin, 1);
        zvs_aux = 0; step(3);

        // R5: short pulse cancels the main turn-on
        tag = "R5"; dly_on = 8'd50; dly_off = 8'd5; cmd = 1; step(10); cmd = 0;
        hits = 0;
        for (int i = 0; i < 80; i++) begin @(negedge clk); if (main_drv) hits++; end
        #1;
        chk(hits == 0, "R5 cancelled turn-on", hits, 0);

        // R6/R7: sleep, wake with the command held high
        tag = "R6"; dly_on = 8'd3; cmd = 1; step(20); enable = 0; step(2);
        chk(aux_oe == 0 && main_drv == 0, "R6 sleep", {aux_oe, main_drv}, 0);
        step(5); tag = "R7"; enable = 1;
        hits = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (main_drv) hits++; end
        #1;
        chk(hits == 0 && aux_oe == 1, "R7 wake waits for edge", hits, 0);
        cmd = 0; step(20);

        // R8: polarity flip while the aux switch is on
        tag = "R8"; aux_invert = 1; step(2);
        chk(aux_pin == 1 && main_drv == 0, "R8 forced off inverted", aux_pin, 1);
        cmd = 1; step(20); cmd = 0; step(20);
        chk(aux_pin == 0, "R8 inverted aux on", aux_pin, 0);
        aux_invert = 0; step(3);
        tag = "";

        // Random stimulus checked by the reference model
        for (int seg = 0; seg < 1500; seg++) begin
            int r = $urandom_range(0, 99);
            if (r < 70) cmd = ~cmd;
            else if (r < 78) zvs_main = ~zvs_main;
            else if (r < 86) zvs_aux = ~zvs_aux;
            else if (r < 92) enable = ~enable;
            else if (r < 96) aux_invert = ~aux_invert;
            else begin
                dly_on = 8'($urandom_range(0, 30));
                dly_off = 8'($urandom_range(0, 30));
            end
            if ($urandom_range(0, 9) == 0) enable = 1;
            step($urandom_range(1, 40));
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule